// File: doc/BRIEF.md
# Program Flow Unit with Single-Entry Return Stack and Two-Source Interrupt Vectoring

This block holds the fetch address of a small nibble-wide processor and decides where the next instruction comes from. A decoder outside the block presents one instruction per `step` pulse, in the form of an operation code, a length flag, a branch-taken flag and a 12-bit target. The block then advances, jumps, branches, calls or returns. It keeps one saved return address, together with a saved carry bit, in a single stack slot.

Two interrupt sources, a real-time clock and a timer, raise level requests that they hold until they are acknowledged. A request is accepted only at an instruction boundary, and only while interrupts are enabled and the stack slot is free. When a request is accepted, the instruction offered in that cycle is not executed. Its address and the current carry are saved, the fetch address moves to the vector of the chosen source, and that source receives a one-cycle acknowledge so it can clear its flag. The real-time clock always wins over the timer.

Top module: `prog_flow_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, `pc` is 000h, interrupts are disabled, the stack slot is free, and `ack_rtc`, `ack_tmr` and `carry_load` are 0.
- R2: With `step`=1 and `op`=0 (advance), `pc` grows by 2 when `len2`=1 and by 1 otherwise, wrapping modulo 4096. `op`=6 (enable) and `op`=7 (disable) advance `pc` by 1.
- R3: `op`=1 (jump) loads all 12 bits of `target` into `pc`.
- R4: `op`=2 (conditional branch) with `br_taken`=1 loads `{pc[11], target[10:0]}`, so bit 11 of the branch's own address is kept. With `br_taken`=0 it loads `pc`+2.
- R5: `op`=3 (call) loads `target` and saves `pc`+2, and does not save the carry. `op`=4 (return) loads the saved address and produces no `carry_load`.
- R6: An accepted interrupt saves the current `pc` and `carry_in`, drops the offered instruction, and loads 008h for the real-time clock or 004h for the timer. `ack_rtc` or `ack_tmr` is high for exactly the one following cycle.
- R7: When both requests are present at acceptance, the real-time clock is acknowledged and the timer request stays pending.
- R8: `op`=5 (return from interrupt) loads the saved address and pulses `carry_load` for one cycle, with `carry_val` equal to the carry saved at interrupt entry.
- R9: No interrupt is accepted while the stack slot is held by a call or by an interrupt. Acceptance resumes at the first boundary after the return or return-from-interrupt.
- R10: Interrupts stay disabled from reset and after a disable until an enable executes. The enable takes effect from the next boundary.
- R11: With `step`=0, `pc` holds its value and no acknowledge is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | An instruction at `pc` is ready to execute |
| op | input | 3 | Operation: 0 advance, 1 jump, 2 branch, 3 call, 4 return, 5 return-from-interrupt, 6 enable, 7 disable |
| len2 | input | 1 | Advance instruction is two bytes long |
| br_taken | input | 1 | Branch condition is true |
| target | input | 12 | Address field of the instruction |
| carry_in | input | 1 | Current carry flag |
| rtc_req | input | 1 | Real-time clock request, held until acknowledged |
| tmr_req | input | 1 | Timer overflow request, held until acknowledged |
| pc | output | 12 | Fetch address |
| carry_load | output | 1 | One-cycle pulse: restore the carry from `carry_val` |
| carry_val | output | 1 | Carry value recovered from the stack |
| ack_rtc | output | 1 | Real-time clock request accepted |
| ack_tmr | output | 1 | Timer request accepted |

## Verification
Assertions check the following properties on every cycle:
- the vector loaded after each acceptance;
- real-time clock priority;
- the absence of acknowledges while the stack slot is held or `step` is low;
- a held `pc` when idle;
- a call leaving the saved carry untouched;
- carry restoration only after a return-from-interrupt.

Only the bench's scenarios can show the following, because each depends on a history of several instructions:
- a timer request surviving a real-time clock acknowledge and being taken after the return;
- deferral across a whole subroutine;
- bit 11 being kept on a taken branch in the upper half of the address space;
- the exact address and carry that come back after an interrupt.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_ADV  = 3'd0,
    OP_JMP  = 3'd1,
    OP_BR   = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5,
    OP_EI   = 3'd6,
    OP_DI   = 3'd7
  } flow_op_e;
endpackage

// File: rtl/pcu_next_pc.sv
module pcu_next_pc #(
  parameter int PC_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  input  pcu_pkg::flow_op_e op,
  input  logic             len2,
  input  logic             br_taken,
  input  logic [PC_W-1:0]  target,
  input  logic [PC_W-1:0]  stk_pc,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  ret_addr
);
  import pcu_pkg::*;

  // Wrapping increment of the fetch address.
  function automatic logic [PC_W-1:0] advance(input logic [PC_W-1:0] a, input logic [1:0] n);
    return a + PC_W'(n);
  endfunction

  // Branch target: upper bit of the current page is kept.
  function automatic logic [PC_W-1:0] page_target(input logic [PC_W-1:0] a, input logic [PC_W-1:0] t);
    return {a[PC_W-1], t[PC_W-2:0]};
  endfunction

  assign ret_addr = advance(pc, 2'd2);

  always_comb begin
    unique case (op)
      OP_ADV:  next_pc = advance(pc, len2 ? 2'd2 : 2'd1);
      OP_JMP:  next_pc = target;
      OP_BR:   next_pc = br_taken ? page_target(pc, target) : advance(pc, 2'd2);
      OP_CALL: next_pc = target;
      OP_RET:  next_pc = stk_pc;
      OP_RETI: next_pc = stk_pc;
      default: next_pc = advance(pc, 2'd1);
    endcase
  end
endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_call,
  input  logic            push_irq,
  input  logic            pop_ret,
  input  logic            pop_reti,
  input  logic [PC_W-1:0] call_addr,
  input  logic [PC_W-1:0] irq_addr,
  input  logic            carry_in,
  output logic [PC_W-1:0] stk_pc,
  output logic            stk_carry,
  output logic            busy,
  output logic            irq_owned
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_pc    <= '0;
      stk_carry <= 1'b0;
      busy      <= 1'b0;
      irq_owned <= 1'b0;
    end else if (push_irq) begin
      stk_pc    <= irq_addr;
      stk_carry <= carry_in;
      busy      <= 1'b1;
      irq_owned <= 1'b1;
    end else if (push_call) begin
      stk_pc    <= call_addr;
      busy      <= 1'b1;
      irq_owned <= 1'b0;
    end else if (pop_ret || pop_reti) begin
      busy      <= 1'b0;
      irq_owned <= 1'b0;
    end
  end

  // R5
  call_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_call && !push_irq |=> stk_carry == $past(stk_carry));

  // R6
  irq_saves_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_irq |=> stk_carry == $past(carry_in) && irq_owned && busy);
endmodule

// File: rtl/pcu_irq.sv
module pcu_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic do_ei,
  input  logic do_di,
  input  logic blocked,
  input  logic rtc_req,
  input  logic tmr_req,
  output logic take,
  output logic take_rtc,
  output logic ie,
  output logic ack_rtc,
  output logic ack_tmr
);
  assign take     = step && ie && !blocked && (rtc_req || tmr_req);
  assign take_rtc = rtc_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      ack_rtc <= 1'b0;
      ack_tmr <= 1'b0;
    end else begin
      ack_rtc <= take && take_rtc;
      ack_tmr <= take && !take_rtc;
      if (do_ei)      ie <= 1'b1;
      else if (do_di) ie <= 1'b0;
    end
  end

  // R7
  rtc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && rtc_req && tmr_req |=> ack_rtc && !ack_tmr);

  // R10
  stay_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie && !do_ei |=> !ie);
endmodule

// File: rtl/prog_flow_unit.sv
module prog_flow_unit #(
  parameter int              PC_W    = 12,
  parameter logic [PC_W-1:0] VEC_TMR = 12'h004,
  parameter logic [PC_W-1:0] VEC_RTC = 12'h008
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [2:0]      op,
  input  logic            len2,
  input  logic            br_taken,
  input  logic [PC_W-1:0] target,
  input  logic            carry_in,
  input  logic            rtc_req,
  input  logic            tmr_req,
  output logic [PC_W-1:0] pc,
  output logic            carry_load,
  output logic            carry_val,
  output logic            ack_rtc,
  output logic            ack_tmr
);
  import pcu_pkg::*;

  flow_op_e        op_e;
  logic [PC_W-1:0] next_pc, ret_addr, stk_pc;
  logic            stk_carry, busy, irq_owned;
  logic            take, take_rtc, ie;
  logic            exec;
  logic            ev_call, ev_ret, ev_reti, ev_ei, ev_di;

  assign op_e    = flow_op_e'(op);
  assign exec    = step && !take;
  assign ev_call = exec && op_e == OP_CALL;
  assign ev_ret  = exec && op_e == OP_RET;
  assign ev_reti = exec && op_e == OP_RETI;
  assign ev_ei   = exec && op_e == OP_EI;
  assign ev_di   = exec && op_e == OP_DI;

  pcu_next_pc #(.PC_W(PC_W)) u_next (
    .pc(pc), .op(op_e), .len2(len2), .br_taken(br_taken), .target(target),
    .stk_pc(stk_pc), .next_pc(next_pc), .ret_addr(ret_addr)
  );

  pcu_stack #(.PC_W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_call(ev_call), .push_irq(take),
    .pop_ret(ev_ret), .pop_reti(ev_reti), .call_addr(ret_addr), .irq_addr(pc),
    .carry_in(carry_in), .stk_pc(stk_pc), .stk_carry(stk_carry),
    .busy(busy), .irq_owned(irq_owned)
  );

  pcu_irq u_irq (
    .clk(clk), .rst_n(rst_n), .step(step), .do_ei(ev_ei), .do_di(ev_di),
    .blocked(busy), .rtc_req(rtc_req), .tmr_req(tmr_req), .take(take),
    .take_rtc(take_rtc), .ie(ie), .ack_rtc(ack_rtc), .ack_tmr(ack_tmr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      carry_load <= 1'b0;
      carry_val  <= 1'b0;
    end else begin
      carry_load <= ev_reti;
      if (ev_reti) carry_val <= stk_carry;
      if (take)      pc <= take_rtc ? VEC_RTC : VEC_TMR;
      else if (step) pc <= next_pc;
    end
  end

  // R6
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc == ($past(rtc_req) ? VEC_RTC : VEC_TMR));

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ack_rtc && !ack_tmr);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && !ack_rtc && !ack_tmr);

  // R8
  carry_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_load |-> $past(step) && $past(op) == 3'd5);

  // R8
  reti_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reti |-> irq_owned);

  // R5
  ret_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret |=> !carry_load && pc == $past(stk_pc));
endmodule

// File: tb/test_prog_flow_unit.sv
module test_prog_flow_unit;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 1'b0, len2 = 1'b0, br_taken = 1'b0, carry_in = 1'b0;
  logic rtc_req = 1'b0, tmr_req = 1'b0;
  logic [2:0] op = 3'd0;
  logic [11:0] target = '0;
  logic [11:0] pc;
  logic carry_load, carry_val, ack_rtc, ack_tmr;

  int checks = 0, errors = 0;

  // Reference state kept by the bench
  logic [11:0] m_pc = '0, m_spc = '0;
  logic m_sc = 1'b0, m_ie = 1'b0, m_busy = 1'b0, m_isr = 1'b0;
  logic m_rtc = 1'b0, m_tmr = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  prog_flow_unit i_prog_flow_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .len2(len2),
    .br_taken(br_taken), .target(target), .carry_in(carry_in),
    .rtc_req(rtc_req), .tmr_req(tmr_req), .pc(pc), .carry_load(carry_load),
    .carry_val(carry_val), .ack_rtc(ack_rtc), .ack_tmr(ack_tmr)
  );

  function automatic logic [11:0] wrap_add(input logic [11:0] a, input int n);
    return 12'((int'(a) + n) % 4096);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, predict, check after the rising edge.
  task automatic cycle(input logic s, input logic [2:0] o, input logic l2,
                       input logic tk, input logic [11:0] t, input logic c);
    logic take, exp_ar, exp_at, exp_cl, exp_cv;
    string tag;
    @(negedge clk);
    step = s; op = o; len2 = l2; br_taken = tk; target = t; carry_in = c;
    rtc_req = m_rtc; tmr_req = m_tmr;
    take = s && m_ie && !m_busy && (m_rtc || m_tmr);
    exp_ar = take && m_rtc;
    exp_at = take && !m_rtc;
    exp_cl = 1'b0; exp_cv = carry_val;
    tag = "R11";
    if (take) begin
      tag = exp_ar ? "R7" : "R6";
      m_spc = m_pc; m_sc = c; m_busy = 1'b1; m_isr = 1'b1;
      m_pc = exp_ar ? 12'h008 : 12'h004;
      if (exp_ar) m_rtc = 1'b0; else m_tmr = 1'b0;
    end else if (s) begin
      case (o)
        3'd0: begin tag = "R2"; m_pc = wrap_add(m_pc, l2 ? 2 : 1); end
        3'd1: begin tag = "R3"; m_pc = t; end
        3'd2: begin tag = "R4"; m_pc = tk ? {m_pc[11], t[10:0]} : wrap_add(m_pc, 2); end
        3'd3: begin tag = "R5"; m_spc = wrap_add(m_pc, 2); m_busy = 1'b1; m_isr = 1'b0; m_pc = t; end
        3'd4: begin tag = "R5"; m_busy = 1'b0; m_pc = m_spc; end
        3'd5: begin tag = "R8"; m_busy = 1'b0; m_isr = 1'b0; m_pc = m_spc; exp_cl = 1'b1; exp_cv = m_sc; end
        3'd6: begin tag = "R10"; m_ie = 1'b1; m_pc = wrap_add(m_pc, 1); end
        default: begin tag = "R10"; m_ie = 1'b0; m_pc = wrap_add(m_pc, 1); end
      endcase
    end
    @(posedge clk); #1;
    check(tag, int'(pc), int'(m_pc));
    check(take ? tag : "R9", int'({ack_rtc, ack_tmr}), int'({exp_ar, exp_at}));
    check("R8", int'(carry_load), int'(exp_cl));
    if (exp_cl) check("R8", int'(carry_val), int'(exp_cv));
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] o;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(pc), 0);
    check("R1", int'({ack_rtc, ack_tmr, carry_load}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(pc), 0);

    // R10: request with interrupts disabled is not taken
    m_tmr = 1'b1;
    cycle(1, 3'd0, 1, 0, 0, 0);
    cycle(1, 3'd0, 0, 0, 0, 0);
    // R7: both pending after enable, RTC first then timer after return
    m_rtc = 1'b1;
    cycle(1, 3'd6, 0, 0, 0, 0);
    cycle(1, 3'd0, 0, 0, 0, 1);
    cycle(1, 3'd0, 0, 0, 0, 0);
    cycle(1, 3'd5, 0, 0, 0, 0);
    cycle(1, 3'd0, 0, 0, 0, 0);
    cycle(1, 3'd5, 0, 0, 0, 0);
    // R9: deferral across a subroutine
    cycle(1, 3'd3, 0, 0, 12'h3A0, 0);
    m_rtc = 1'b1; m_tmr = 1'b1;
    cycle(1, 3'd0, 1, 0, 0, 0);
    cycle(0, 3'd0, 0, 0, 0, 0);
    cycle(1, 3'd4, 0, 0, 0, 0);
    cycle(1, 3'd0, 0, 0, 0, 1);
    cycle(1, 3'd5, 0, 0, 0, 0);
    cycle(1, 3'd0, 0, 0, 0, 0);
    cycle(1, 3'd5, 0, 0, 0, 0);
    // R4: bit 11 kept on a taken branch in the upper half
    cycle(1, 3'd1, 0, 0, 12'h9F0, 0);
    cycle(1, 3'd2, 0, 1, 12'h123, 0);
    cycle(1, 3'd2, 0, 0, 12'h456, 0);
    // R2: wrap at the top of the address space
    cycle(1, 3'd1, 0, 0, 12'hFFF, 0);
    cycle(1, 3'd0, 1, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      o = 3'($urandom_range(0, 7));
      if (!m_busy && (o == 3'd4 || o == 3'd5)) o = 3'd0;
      if (m_busy && !m_isr && (o == 3'd3 || o == 3'd5)) o = 3'd0;
      if (m_isr && (o == 3'd3 || o == 3'd4)) o = 3'd2;
      if (!m_rtc && $urandom_range(0, 15) == 0) m_rtc = 1'b1;
      if (!m_tmr && $urandom_range(0, 11) == 0) m_tmr = 1'b1;
      cycle(1'($urandom_range(0, 5) != 0), o, 1'($urandom), 1'($urandom),
            12'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule